// File: doc/BRIEF.md
# Serial Controller Programming Sequencer

This block is the processor-facing register front end of a programmable serial controller. A host reaches it through a chip select, separate read and write strobes, a control/data select line, and separate input and output byte buses. The block turns these accesses into register loads and one-cycle strobes. The serial shifter and receiver logic sit outside the block and connect through flag inputs and strobe outputs.

After any reset, control writes follow a fixed order. The first one loads the mode word. In synchronous mode one or two sync characters come next. Every later control write loads the command register, and a command with its internal-reset bit set sends the sequence back to the start. Data writes load the transmit buffer. Control reads return an assembled status byte and data reads return the receive byte. The block also drives the active-low modem outputs for terminal ready and request to send from the command bits.

Top module: `serial_prog_seq`

## Requirements
- R1: After a hardware or internal reset, the first control write (ctlSel=1) loads modeWord. Mode bits 1:0 = 00 select synchronous operation; any other value selects asynchronous operation.
- R2: In synchronous mode the next control write loads syncOne. The write after that loads syncTwo only when mode bit 7 is 0. In asynchronous mode both sync loads are skipped and syncOne/syncTwo keep their value.
- R3: Once the mode and sync steps are done, each control write loads the command. Bit 0 drives txEnable, bit 2 drives rxEnable, bit 3 drives sendBreak, bit 1 set drives dtrN low, and bit 5 set drives rtsN low.
- R4: A command write with bit 6 set performs an internal reset at that clock edge. It clears the mode, sync, command and transmit registers and the error flags, makes the next control write load the mode word, and none of the other bits of that write take effect.
- R5: The parity, overrun and framing error flags are set by one-cycle pulses on parErrSet, ovrErrSet and frmErrSet and stay set. They are cleared by a command write with bit 4 set, and by either kind of reset. If a set and a clear arrive in the same cycle, the clear wins.
- R6: With ctlSel=1, dataOut carries the status byte. Bit 0 is txRdyIn, bit 1 rxRdyIn, bit 2 txEmptyIn, bit 3 parity error, bit 4 overrun error, bit 5 framing error, bit 6 syncBrkIn, and bit 7 the inverse of dsrN.
- R7: With ctlSel=0, dataOut carries rxDataIn. A data write loads txData and pulses txLoadStb for one cycle, but only after programming is complete. A data write made earlier is ignored.
- R8: outEnN is low exactly while csN and rdN are both low.
- R9: The start of each read pulses one strobe for one cycle: rxReadStb for a data read, statusReadStb for a control read.
- R10: A command write with bit 7 set pulses huntStb for one cycle when the mode is synchronous. In asynchronous mode the bit has no effect.
- R11: rstN is an active-low asynchronous reset. It clears all registers and strobes and sets dtrN and rtsN high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| ctlSel | input | 1 | 1 selects control/status, 0 selects data |
| dataIn | input | 8 | Write data bus |
| dataOut | output | 8 | Read data bus (status or receive byte) |
| outEnN | output | 1 | Read bus enable, active low |
| dsrN | input | 1 | Data set ready input, active low |
| dtrN | output | 1 | Terminal ready output, active low |
| rtsN | output | 1 | Request to send output, active low |
| txRdyIn | input | 1 | Transmit buffer free flag |
| rxRdyIn | input | 1 | Receive byte waiting flag |
| txEmptyIn | input | 1 | Transmitter idle flag |
| syncBrkIn | input | 1 | Sync or break detected flag |
| parErrSet | input | 1 | Parity error pulse |
| ovrErrSet | input | 1 | Overrun error pulse |
| frmErrSet | input | 1 | Framing error pulse |
| rxDataIn | input | 8 | Received byte |
| modeWord | output | 8 | Stored mode word |
| syncOne | output | 8 | First sync character |
| syncTwo | output | 8 | Second sync character |
| txEnable | output | 1 | Transmitter enable |
| rxEnable | output | 1 | Receiver enable |
| sendBreak | output | 1 | Force break on the line |
| huntStb | output | 1 | One-cycle request to hunt for sync |
| txData | output | 8 | Transmit buffer byte |
| txLoadStb | output | 1 | One-cycle transmit buffer load strobe |
| rxReadStb | output | 1 | One-cycle receive byte read strobe |
| statusReadStb | output | 1 | One-cycle status read strobe |

## Verification
An access is taken at the first rising edge that sees it active. Register contents, modem outputs, error flags and the four strobes therefore change at that same edge and are visible during the following cycle. dataOut and outEnN are combinational and follow their inputs within the cycle. The bench keeps a behavioural model that advances at every rising edge using the inputs held stable across that edge, and compares each output 1 ns after the edge. This covers both the registered results and the same-cycle combinational ones.

// File: rtl/serial_prog_seq_pkg.sv
package serial_prog_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_MODE  = 2'd0,
    SEQ_SYNC1 = 2'd1,
    SEQ_SYNC2 = 2'd2,
    SEQ_CMD   = 2'd3
  } seqState_t;

  typedef struct packed {
    logic ldMode;
    logic ldSyncOne;
    logic ldSyncTwo;
    logic ldCmd;
    logic ldTx;
    logic errClr;
    logic intRst;
    logic rdRx;
    logic rdStat;
    logic huntReq;
  } busStb_t;

  localparam int CMD_TXEN  = 0;
  localparam int CMD_DTR   = 1;
  localparam int CMD_RXEN  = 2;
  localparam int CMD_BRK   = 3;
  localparam int CMD_ERST  = 4;
  localparam int CMD_RTS   = 5;
  localparam int CMD_IRST  = 6;
  localparam int CMD_HUNT  = 7;
  localparam int MODE_SCS  = 7;
endpackage

// File: rtl/serial_prog_seq_ctrl.sv
module serial_prog_seq_ctrl
  import serial_prog_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              ctlSel,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              modeSync,
  input  logic              modeSingle,
  output logic              outEnN,
  output busStb_t           stb
);
  logic wrAct, rdAct, wrActQ, rdActQ, wrStart, rdStart, ctlWr;
  seqState_t seqState, seqNext;

  assign wrAct   = !csN && !wrN;
  assign rdAct   = !csN && !rdN;
  assign wrStart = wrAct && !wrActQ;
  assign rdStart = rdAct && !rdActQ;
  assign ctlWr   = wrStart && ctlSel;
  assign outEnN  = !rdAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActQ   <= 1'b0;
      rdActQ   <= 1'b0;
      seqState <= SEQ_MODE;
    end else begin
      wrActQ   <= wrAct;
      rdActQ   <= rdAct;
      seqState <= seqNext;
    end
  end

  always_comb begin
    seqNext = seqState;
    if (ctlWr) begin
      unique case (seqState)
        SEQ_MODE:  seqNext = (dataIn[1:0] == 2'b00) ? SEQ_SYNC1 : SEQ_CMD;
        SEQ_SYNC1: seqNext = modeSingle ? SEQ_CMD : SEQ_SYNC2;
        SEQ_SYNC2: seqNext = SEQ_CMD;
        SEQ_CMD:   seqNext = dataIn[CMD_IRST] ? SEQ_MODE : SEQ_CMD;
        default:   seqNext = SEQ_MODE;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.ldMode    = ctlWr && (seqState == SEQ_MODE);
    stb.ldSyncOne = ctlWr && (seqState == SEQ_SYNC1);
    stb.ldSyncTwo = ctlWr && (seqState == SEQ_SYNC2);
    stb.intRst    = ctlWr && (seqState == SEQ_CMD) && dataIn[CMD_IRST];
    stb.ldCmd     = ctlWr && (seqState == SEQ_CMD) && !dataIn[CMD_IRST];
    stb.errClr    = stb.ldCmd && dataIn[CMD_ERST];
    stb.huntReq   = stb.ldCmd && dataIn[CMD_HUNT] && modeSync;
    stb.ldTx      = wrStart && !ctlSel && (seqState == SEQ_CMD);
    stb.rdRx      = rdStart && !ctlSel;
    stb.rdStat    = rdStart && ctlSel;
  end
endmodule

// File: rtl/serial_prog_seq_dp.sv
module serial_prog_seq_dp
  import serial_prog_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ERR_N  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStb_t           stb,
  input  logic              ctlSel,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] rxDataIn,
  input  logic              dsrN,
  input  logic              txRdyIn,
  input  logic              rxRdyIn,
  input  logic              txEmptyIn,
  input  logic              syncBrkIn,
  input  logic [ERR_N-1:0]  errSet,
  output logic [ERR_N-1:0]  errFlags,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] modeWord,
  output logic [DATA_W-1:0] syncOne,
  output logic [DATA_W-1:0] syncTwo,
  output logic [DATA_W-1:0] cmdWord,
  output logic [DATA_W-1:0] txData,
  output logic              txLoadStb,
  output logic              rxReadStb,
  output logic              statusReadStb,
  output logic              huntStb
);
  logic [7:0] statusByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeWord      <= '0;
      syncOne       <= '0;
      syncTwo       <= '0;
      cmdWord       <= '0;
      txData        <= '0;
      errFlags      <= '0;
      txLoadStb     <= 1'b0;
      rxReadStb     <= 1'b0;
      statusReadStb <= 1'b0;
      huntStb       <= 1'b0;
    end else if (stb.intRst) begin
      modeWord      <= '0;
      syncOne       <= '0;
      syncTwo       <= '0;
      cmdWord       <= '0;
      txData        <= '0;
      errFlags      <= '0;
      txLoadStb     <= 1'b0;
      rxReadStb     <= 1'b0;
      statusReadStb <= 1'b0;
      huntStb       <= 1'b0;
    end else begin
      if (stb.ldMode)    modeWord <= dataIn;
      if (stb.ldSyncOne) syncOne  <= dataIn;
      if (stb.ldSyncTwo) syncTwo  <= dataIn;
      if (stb.ldCmd)     cmdWord  <= dataIn;
      if (stb.ldTx)      txData   <= dataIn;
      errFlags      <= stb.errClr ? '0 : (errFlags | errSet);
      txLoadStb     <= stb.ldTx;
      rxReadStb     <= stb.rdRx;
      statusReadStb <= stb.rdStat;
      huntStb       <= stb.huntReq;
    end
  end

  assign statusByte = {!dsrN, syncBrkIn, errFlags[2], errFlags[1], errFlags[0],
                       txEmptyIn, rxRdyIn, txRdyIn};

  generate
    if (DATA_W > 8) begin : g_wide
      assign dataOut = ctlSel ? {{(DATA_W-8){1'b0}}, statusByte} : rxDataIn;
    end else begin : g_byte
      assign dataOut = ctlSel ? statusByte[DATA_W-1:0] : rxDataIn;
    end
  endgenerate
endmodule

// File: rtl/serial_prog_seq.sv
module serial_prog_seq
  import serial_prog_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              ctlSel,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              outEnN,
  input  logic              dsrN,
  output logic              dtrN,
  output logic              rtsN,
  input  logic              txRdyIn,
  input  logic              rxRdyIn,
  input  logic              txEmptyIn,
  input  logic              syncBrkIn,
  input  logic              parErrSet,
  input  logic              ovrErrSet,
  input  logic              frmErrSet,
  input  logic [DATA_W-1:0] rxDataIn,
  output logic [DATA_W-1:0] modeWord,
  output logic [DATA_W-1:0] syncOne,
  output logic [DATA_W-1:0] syncTwo,
  output logic              txEnable,
  output logic              rxEnable,
  output logic              sendBreak,
  output logic              huntStb,
  output logic [DATA_W-1:0] txData,
  output logic              txLoadStb,
  output logic              rxReadStb,
  output logic              statusReadStb
);
  localparam int ERR_N = 3;

  busStb_t           stb;
  logic [ERR_N-1:0]  errFlags;
  logic [DATA_W-1:0] cmdWord;

  serial_prog_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .ctlSel(ctlSel), .dataIn(dataIn),
    .modeSync(modeWord[1:0] == 2'b00), .modeSingle(modeWord[MODE_SCS]),
    .outEnN(outEnN), .stb(stb)
  );

  serial_prog_seq_dp #(.DATA_W(DATA_W), .ERR_N(ERR_N)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ctlSel(ctlSel), .dataIn(dataIn),
    .rxDataIn(rxDataIn), .dsrN(dsrN), .txRdyIn(txRdyIn), .rxRdyIn(rxRdyIn),
    .txEmptyIn(txEmptyIn), .syncBrkIn(syncBrkIn),
    .errSet({frmErrSet, ovrErrSet, parErrSet}), .errFlags(errFlags),
    .dataOut(dataOut), .modeWord(modeWord), .syncOne(syncOne),
    .syncTwo(syncTwo), .cmdWord(cmdWord), .txData(txData),
    .txLoadStb(txLoadStb), .rxReadStb(rxReadStb),
    .statusReadStb(statusReadStb), .huntStb(huntStb)
  );

  assign txEnable  = cmdWord[CMD_TXEN];
  assign rxEnable  = cmdWord[CMD_RXEN];
  assign sendBreak = cmdWord[CMD_BRK];
  assign dtrN      = !cmdWord[CMD_DTR];
  assign rtsN      = !cmdWord[CMD_RTS];
endmodule

// File: rtl/serial_prog_seq_chk.sv
module serial_prog_seq_chk
  import serial_prog_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rdN,
  input logic [DATA_W-1:0] dataIn,
  input logic              outEnN,
  input logic              dtrN,
  input logic              rtsN,
  input logic [DATA_W-1:0] modeWord,
  input logic              txEnable,
  input logic              huntStb,
  input logic              txLoadStb,
  input logic              rxReadStb,
  input logic              statusReadStb,
  input busStb_t           stb,
  input logic [2:0]        errFlags
);
  p_outen_r8: assert property (@(posedge clk) disable iff (!rstN)
    !outEnN |-> (!csN && !rdN));

  p_rx_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxReadStb |=> !rxReadStb);

  p_stat_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    statusReadStb |=> !statusReadStb);

  p_modem_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldCmd |=> (dtrN == !$past(dataIn[CMD_DTR])) && (rtsN == !$past(dataIn[CMD_RTS])));

  p_int_reset_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.intRst |=> (modeWord == '0) && !txEnable && (errFlags == '0) && dtrN && rtsN);

  p_err_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.errClr |=> (errFlags == '0));

  p_tx_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    txLoadStb |-> $past(stb.ldTx));

  p_hunt_sync_r10: assert property (@(posedge clk) disable iff (!rstN)
    huntStb |-> (modeWord[1:0] == 2'b00));
endmodule

bind serial_prog_seq serial_prog_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .dataIn(dataIn),
  .outEnN(outEnN), .dtrN(dtrN), .rtsN(rtsN), .modeWord(modeWord),
  .txEnable(txEnable), .huntStb(huntStb), .txLoadStb(txLoadStb),
  .rxReadStb(rxReadStb), .statusReadStb(statusReadStb),
  .stb(stb), .errFlags(errFlags)
);

// File: tb/serial_prog_seq_bench.sv
`timescale 1ns/1ps
module serial_prog_seq_bench;
  logic clk = 1'b0;
  always #2 clk = !clk;

  logic rstN = 1'b0, csN = 1'b1, rdN = 1'b1, wrN = 1'b1, ctlSel = 1'b0;
  logic [7:0] dataIn = '0, rxDataIn = '0;
  logic dsrN = 1'b1, txRdyIn = 1'b0, rxRdyIn = 1'b0, txEmptyIn = 1'b0, syncBrkIn = 1'b0;
  logic parErrSet = 1'b0, ovrErrSet = 1'b0, frmErrSet = 1'b0;
  logic [7:0] dataOut, modeWord, syncOne, syncTwo, txData;
  logic outEnN, dtrN, rtsN, txEnable, rxEnable, sendBreak;
  logic huntStb, txLoadStb, rxReadStb, statusReadStb;

  serial_prog_seq u_serial_prog_seq (.*);

  int nChecks = 0, nErrors = 0;
  bit done = 0;

  // behavioural reference
  int mSeq;
  logic [7:0] mMode, mS1, mS2, mCmd, mTx;
  logic [2:0] mErr;
  logic mWrQ, mRdQ, eTx, eRx, eSt, eHu;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSeq = 0; mMode = 0; mS1 = 0; mS2 = 0; mCmd = 0; mTx = 0; mErr = 0;
      mWrQ = 0; mRdQ = 0; eTx = 0; eRx = 0; eSt = 0; eHu = 0;
    end else begin
      logic wrA, rdA, wrS, rdS;
      logic [2:0] nErr;
      wrA = !csN && !wrN; rdA = !csN && !rdN;
      wrS = wrA && !mWrQ; rdS = rdA && !mRdQ;
      eTx = 0; eHu = 0;
      eRx = rdS && !ctlSel; eSt = rdS && ctlSel;
      nErr = mErr | {frmErrSet, ovrErrSet, parErrSet};
      if (wrS && ctlSel) begin
        if (mSeq == 0) begin mMode = dataIn; mSeq = (dataIn[1:0] == 0) ? 1 : 3; end
        else if (mSeq == 1) begin mS1 = dataIn; mSeq = mMode[7] ? 3 : 2; end
        else if (mSeq == 2) begin mS2 = dataIn; mSeq = 3; end
        else if (dataIn[6]) begin
          mSeq = 0; mMode = 0; mS1 = 0; mS2 = 0; mCmd = 0; mTx = 0; nErr = 0;
          eRx = 0; eSt = 0;
        end else begin
          mCmd = dataIn;
          if (dataIn[4]) nErr = 0;
          eHu = dataIn[7] && (mMode[1:0] == 0);
        end
      end
      if (wrS && !ctlSel && mSeq == 3) begin mTx = dataIn; eTx = 1; end
      mErr = nErr; mWrQ = wrA; mRdQ = rdA;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      logic [7:0] eOut;
      eOut = ctlSel ? {!dsrN, syncBrkIn, mErr, txEmptyIn, rxRdyIn, txRdyIn} : rxDataIn;
      chk(modeWord === mMode, "R1 modeWord", modeWord, mMode);
      chk({syncOne, syncTwo} === {mS1, mS2}, "R2 sync chars", {syncOne, syncTwo}, {mS1, mS2});
      chk({txEnable, rxEnable, sendBreak, dtrN, rtsN} === {mCmd[0], mCmd[2], mCmd[3], !mCmd[1], !mCmd[5]},
          "R3 command outputs", {txEnable, rxEnable, sendBreak, dtrN, rtsN},
          {mCmd[0], mCmd[2], mCmd[3], !mCmd[1], !mCmd[5]});
      chk(dataOut === eOut, ctlSel ? "R6 status byte" : "R7 rx data", dataOut, eOut);
      chk({txData, txLoadStb} === {mTx, eTx}, "R7 tx buffer", {txData, txLoadStb}, {mTx, eTx});
      chk(outEnN === !(!csN && !rdN), "R8 outEnN", outEnN, !(!csN && !rdN));
      chk({rxReadStb, statusReadStb} === {eRx, eSt}, "R9 read strobes", {rxReadStb, statusReadStb}, {eRx, eSt});
      chk(huntStb === eHu, "R10 huntStb", huntStb, eHu);
    end
  end

  task automatic wrAcc(input logic sel, input logic [7:0] d);
    @(negedge clk); ctlSel = sel; dataIn = d; csN = 0; wrN = 0;
    @(negedge clk); wrN = 1; csN = 1;
    @(negedge clk);
  endtask

  task automatic rdAcc(input logic sel);
    @(negedge clk); ctlSel = sel; csN = 0; rdN = 0;
    @(negedge clk); @(negedge clk); rdN = 1; csN = 1;
    @(negedge clk);
  endtask

  task automatic errPulse(input logic [2:0] f);
    @(negedge clk); {frmErrSet, ovrErrSet, parErrSet} = f;
    @(negedge clk); {frmErrSet, ovrErrSet, parErrSet} = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; nErrors++; nChecks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk({dtrN, rtsN, modeWord, txLoadStb} === {2'b11, 8'h00, 1'b0}, "R11 reset state",
        {dtrN, rtsN, modeWord, txLoadStb}, {2'b11, 8'h00, 1'b0});
    rstN = 1;
    // R7: data write before programming is ignored
    wrAcc(0, 8'hA5);
    chk(txData === 8'h00, "R7 early data write ignored", txData, 8'h00);
    // R1/R2: async mode skips sync chars
    wrAcc(1, 8'h4E);
    wrAcc(1, 8'h27);
    chk({syncOne, txEnable, dtrN, rtsN} === {8'h00, 1'b1, 1'b0, 1'b0}, "R2 async skips sync",
        {syncOne, txEnable, dtrN, rtsN}, {8'h00, 1'b1, 1'b0, 1'b0});
    wrAcc(0, 8'h3C);
    rxDataIn = 8'h96; rdAcc(0);
    txRdyIn = 1; txEmptyIn = 1; dsrN = 0; rdAcc(1);
    // R10: hunt bit ignored in async
    wrAcc(1, 8'h85);
    // R5: errors set then cleared, clear beats simultaneous set
    errPulse(3'b101); ctlSel = 1; rxRdyIn = 1; syncBrkIn = 1;
    @(negedge clk);
    chk(dataOut[5:3] === 3'b101, "R5 error flags sticky", dataOut[5:3], 3'b101);
    errPulse(3'b010);
    @(negedge clk); ctlSel = 1; dataIn = 8'h15; csN = 0; wrN = 0; parErrSet = 1;
    @(negedge clk); wrN = 1; csN = 1; parErrSet = 0;
    chk(dataOut[5:3] === 3'b000, "R5 error reset wins", dataOut[5:3], 3'b000);
    // R4: internal reset
    errPulse(3'b011);
    wrAcc(1, 8'hE3);
    chk({modeWord, txData, dtrN, dataOut[5:3]} === {8'h00, 8'h00, 1'b1, 3'b000}, "R4 internal reset",
        {modeWord, txData, dtrN, dataOut[5:3]}, {8'h00, 8'h00, 1'b1, 3'b000});
    // R2: sync mode with single sync char
    wrAcc(1, 8'h8C); wrAcc(1, 8'h16); wrAcc(1, 8'h84);
    chk({syncOne, syncTwo} === {8'h16, 8'h00}, "R2 single sync", {syncOne, syncTwo}, {8'h16, 8'h00});
    wrAcc(0, 8'h55);
    wrAcc(1, 8'h40);
    // R2: sync mode with two sync chars, hunt
    wrAcc(1, 8'h1C); wrAcc(1, 8'h32); wrAcc(1, 8'h4B); wrAcc(1, 8'hA6);
    chk({syncOne, syncTwo, rxEnable} === {8'h32, 8'h4B, 1'b1}, "R2 double sync",
        {syncOne, syncTwo, rxEnable}, {8'h32, 8'h4B, 1'b1});
    wrAcc(0, 8'hC3); rdAcc(1); rdAcc(0);
    // R11: asynchronous reset mid-run
    @(negedge clk); #1 rstN = 0;
    #0.5;
    chk({modeWord, dtrN} === {8'h00, 1'b1}, "R11 async reset", {modeWord, dtrN}, {8'h00, 1'b1});
    @(negedge clk); rstN = 1;
    wrAcc(1, 8'hCF); wrAcc(1, 8'h08);
    chk(sendBreak === 1'b1, "R3 send break", sendBreak, 1'b1);
    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule